// File: doc/BRIEF.md
# I2C to Asynchronous SRAM Bridge

The block is an I2C slave that lets a bus master read and write an external asynchronous SRAM. A write transaction carries a 20-bit memory address and one data byte. The bridge places the address and the data on the SRAM buses, then asserts chip select and write enable together for a single clock. A read transaction is a streaming download. The bridge selects the memory with output enable active and presents bytes starting from address 0. It steps the address after each byte that the master acknowledges, and it stops when the master does not acknowledge or ends the transfer.

On the bus side, SCL and SDA are inputs. SDA is driven only by pulling it low through `sda_oe`, as on an open-drain line. Both lines are synchronised and decoded with a sampling clock that runs several times faster than SCL. In each write, the address bytes are sent most significant first. The upper four bits of the first address byte are ignored.

Top module: `i2c_sram_bridge`

## Requirements
- R1: After reset, mem_csz, mem_wez and mem_oez are high, mem_dq_oe is low and sda_oe is low.
- R2: The bridge acknowledges a device address byte whose upper seven bits equal 0000101. Bit 0 of that byte selects the direction: 0 is write and 1 is read. Any other device address gets no acknowledge and causes no SRAM access.
- R3: A write sends three address bytes, most significant first, and then one data byte, and each of these bytes is acknowledged. Bits 7..4 of the first address byte are ignored, so the memory address is {byte1[3:0], byte2, byte3}.
- R4: After the data byte of a write, the bridge drives the address and the data, with mem_dq_oe high, for at least one clock. It then holds mem_csz and mem_wez low together for exactly one clock while mem_oez stays high. The addressed location takes the data byte.
- R5: A byte that follows the data byte in the same write transaction is not acknowledged and causes no further strobe.
- R6: While a read transaction is active, mem_csz and mem_oez are low, mem_wez is high and mem_dq_oe is low.
- R7: Each read transaction starts at memory address 0. Each byte is shifted out most significant bit first, and a 0 bit is sent by pulling SDA low.
- R8: When the master acknowledges a read byte, the address advances by one and the next byte comes from that address.
- R9: When the master does not acknowledge a read byte, streaming ends: SDA is released and mem_csz returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, several times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mem_addr | output | 20 | SRAM address |
| mem_dq_out | output | 8 | SRAM write data |
| mem_dq_oe | output | 1 | Drive the SRAM data bus when 1 |
| mem_dq_in | input | 8 | SRAM read data |
| mem_csz | output | 1 | SRAM chip select, active low |
| mem_wez | output | 1 | SRAM write enable, active low |
| mem_oez | output | 1 | SRAM output enable, active low |

## Verification
The hardest condition to reach is the end of a streaming read. Reaching it needs a complete read transaction in which several bytes are acknowledged and the last one is not, followed by a second read that must begin again at address 0. The bench plays an I2C master that chooses the acknowledge bit for each byte it receives. A bench memory model seeds each location with a distinct value, so a repeated or skipped address shows up as a wrong byte. A second case sends a fifth byte after a completed write, to show that it gets no acknowledge and causes no second strobe.

// File: rtl/i2c_sram_bridge.sv
module i2c_sram_bridge #(
  parameter logic [6:0] DEV_ADDR = 7'b0000101,
  parameter int         AW       = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_dq_in,
  output logic          mem_csz,
  output logic          mem_wez,
  output logic          mem_oez
);
  localparam int HB = AW - 16;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ACK, S_WR, S_RD, S_MACK} st_t;

  st_t           st;
  logic [2:0]    scl_s, sda_s;
  logic [7:0]    sr, wd;
  logic [3:0]    cnt;
  logic [2:0]    bidx;
  logic [1:0]    wst;
  logic          rw, mack;
  logic [AW-1:0] wa, rd_addr;

  wire scl_r   = scl_s[1] & ~scl_s[2];
  wire scl_f   = ~scl_s[1] & scl_s[2];
  wire sda_v   = sda_s[1];
  wire scl_hi  = scl_s[1] & scl_s[2];
  wire start   = scl_hi & ~sda_s[1] & sda_s[2];
  wire stop    = scl_hi & sda_s[1] & ~sda_s[2];
  wire [7:0] byte_in = {sr[6:0], sda_v};
  wire reading = rw & (st == S_ACK || st == S_RD || st == S_MACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl};
      sda_s <= {sda_s[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sr <= '0; wd <= '0; cnt <= '0; bidx <= '0;
      wst <= '0; rw <= 1'b0; mack <= 1'b0; wa <= '0; rd_addr <= '0;
    end else begin
      if (wst == 2'd1)      wst <= 2'd2;
      else if (wst == 2'd2) wst <= 2'd0;
      if (start) begin
        st <= S_DEV; cnt <= '0; bidx <= '0; rw <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_DEV:
            if (scl_r) begin
              sr  <= byte_in;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (byte_in[7:1] != DEV_ADDR) st <= S_IDLE;
                else begin
                  rw      <= byte_in[0];
                  rd_addr <= '0;
                end
              end
            end else if (scl_f && cnt == 4'd8) st <= S_ACK;
          S_WR:
            if (scl_r) begin
              sr  <= byte_in;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                case (bidx)
                  3'd0:    wa[AW-1:16] <= byte_in[HB-1:0];
                  3'd1:    wa[15:8]    <= byte_in;
                  3'd2:    wa[7:0]     <= byte_in;
                  default: begin wd <= byte_in; wst <= 2'd1; end
                endcase
                bidx <= bidx + 3'd1;
              end
            end else if (scl_f && cnt == 4'd8) st <= S_ACK;
          S_ACK:
            if (scl_f) begin
              cnt <= '0;
              if (rw) begin
                st <= S_RD;
                sr <= mem_dq_in;
              end else begin
                st <= (bidx == 3'd4) ? S_IDLE : S_WR;
              end
            end
          S_RD:
            if (scl_f) begin
              if (cnt == 4'd7) st <= S_MACK;
              else begin
                sr  <= {sr[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          S_MACK:
            if (scl_r) begin
              mack <= ~sda_v;
              if (!sda_v) rd_addr <= rd_addr + 1'b1;
            end else if (scl_f) begin
              if (mack) begin
                st  <= S_RD;
                sr  <= mem_dq_in;
                cnt <= '0;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe     = (st == S_ACK) | ((st == S_RD) & ~sr[7]);
  assign mem_addr   = reading ? rd_addr : wa;
  assign mem_dq_out = wd;
  assign mem_dq_oe  = (wst != 2'd0);
  assign mem_wez    = ~(wst == 2'd2);
  assign mem_csz    = ~(reading | (wst == 2'd2));
  assign mem_oez    = ~reading;

  AST_WR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wez |=> mem_wez);                                               // R4
  AST_WR_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wez |-> (!mem_csz && mem_oez && mem_dq_oe));                    // R4
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wez) |-> ($past(mem_dq_oe) && $stable(mem_dq_out) && $stable(mem_addr))); // R4
  AST_RD_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oez |-> (!mem_csz && mem_wez && !mem_dq_oe));                   // R6
  AST_RD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oez) |-> (mem_addr == '0));                                // R7
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oez && $past(!mem_oez)) |->
      (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + 1'b1)); // R8
  AST_NACK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && scl_f && !mack && !start && !stop) |=> (!sda_oe && mem_csz)); // R9
endmodule

// File: tb/i2c_sram_bridge_bench.sv
module i2c_sram_bridge_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [19:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic        mem_dq_oe, mem_csz, mem_wez, mem_oez;
  wire         sda_bus = sda_m & ~sda_oe;

  logic [7:0]  mem [256];
  int total = 0, bad = 0, cyc = 0;
  int strobes = 0, setup_bad = 0, wide_bad = 0, rd_bad = 0;
  logic [19:0] last_addr;
  logic        prev_low = 1'b0, prev_dqoe = 1'b0;
  bit          finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_sram_bridge u_i2c_sram_bridge (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_csz(mem_csz), .mem_wez(mem_wez), .mem_oez(mem_oez));

  assign mem_dq_in = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (!mem_csz && !mem_wez) begin
        mem[mem_addr[7:0]] <= mem_dq_out;
        strobes++;
        last_addr <= mem_addr;
        if (!prev_dqoe || !mem_oez == 1'b1) setup_bad++;
        if (prev_low) wide_bad++;
      end
      if (!mem_oez && (mem_csz || !mem_wez || mem_dq_oe)) rd_bad++;
    end
    prev_low  <= !mem_wez;
    prev_dqoe <= mem_dq_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // {addr byte 1, addr byte 2, addr byte 3, data, expected 20-bit address}
  localparam logic [51:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h40, 8'h5A, 20'h00040},
    {8'h01, 8'h23, 8'h41, 8'hC3, 20'h12341},
    {8'hA3, 8'h00, 8'h42, 8'hFF, 20'h30042},
    {8'h0F, 8'hFF, 8'h43, 8'h00, 20'hFFF43},
    {8'h00, 8'h20, 8'h44, 8'h81, 20'h02044},
    {8'hF0, 8'h00, 8'h45, 8'h7E, 20'h00045}
  };

  initial begin
    bit          a0, a1, a2, a3, a4;
    logic [7:0]  rb;
    int          s0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "csz after reset", mem_csz, 1);
    chk("R1", "wez after reset", mem_wez, 1);
    chk("R1", "oez after reset", mem_oez, 1);
    chk("R1", "dq_oe after reset", mem_dq_oe, 0);
    chk("R1", "sda_oe after reset", sda_oe, 0);

    foreach (VEC[k]) begin
      s0 = strobes;
      bstart();
      wbyte(8'h0A, a0); wbyte(VEC[k][51:44], a1); wbyte(VEC[k][43:36], a2);
      wbyte(VEC[k][35:28], a3); wbyte(VEC[k][27:20], a4);
      bstop();
      chk("R2", "device address ack", a0, 1);
      chk("R3", "address and data acks", {a1, a2, a3, a4}, 4'hF);
      chk("R4", "one strobe per write", strobes - s0, 1);
      chk("R3", "strobed address", last_addr, VEC[k][19:0]);
      chk("R4", "stored byte", mem[VEC[k][27:20] == 8'h00 ? VEC[k][35:28] : VEC[k][35:28]], VEC[k][27:20]);
    end

    s0 = strobes;
    bstart(); wbyte(8'h0C, a0); wbyte(8'h00, a1); wbyte(8'h00, a2);
    wbyte(8'h60, a3); wbyte(8'h99, a4); bstop();
    chk("R2", "foreign address not acked", a0, 0);
    chk("R2", "no access on foreign address", strobes - s0, 0);
    chk("R2", "memory untouched", mem[8'h60], 8'(8'h60 * 7 + 3));

    s0 = strobes;
    bstart(); wbyte(8'h0A, a0); wbyte(8'h00, a1); wbyte(8'h00, a2);
    wbyte(8'h50, a3); wbyte(8'h11, a4); wbyte(8'h22, a1); bstop();
    chk("R5", "extra byte not acked", a1, 0);
    chk("R5", "single strobe", strobes - s0, 1);
    chk("R5", "first data kept", mem[8'h50], 8'h11);

    bstart(); wbyte(8'h0B, a0);
    chk("R2", "read address ack", a0, 1);
    rbyte(1'b1, rb);
    chk("R7", "first byte from address 0", rb, 8'h03);
    chk("R6", "csz low in read", mem_csz, 0);
    chk("R6", "oez low in read", mem_oez, 0);
    chk("R6", "wez high in read", mem_wez, 1);
    rbyte(1'b1, rb); chk("R8", "byte at address 1", rb, 8'h0A);
    rbyte(1'b1, rb); chk("R8", "byte at address 2", rb, 8'h11);
    rbyte(1'b0, rb); chk("R8", "byte at address 3", rb, 8'h18);
    chk("R9", "sda released after nack", sda_oe, 0);
    chk("R9", "csz high after nack", mem_csz, 1);
    bstop();

    bstart(); wbyte(8'h0B, a0); rbyte(1'b0, rb); bstop();
    chk("R7", "second read restarts at 0", rb, 8'h03);

    chk("R4", "data set up before strobe", setup_bad, 0);
    chk("R4", "strobe exactly one clock", wide_bad, 0);
    chk("R6", "read line levels", rd_bad, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule